// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a single-channel 24-bit interval timer behind a small 32-bit register port. Software writes an initial count and a control word. The control word holds the run enable, the periodic/one-shot selection, a sticky underflow flag and an 8-bit prescale ratio. While the timer runs, the counter steps down once every P+1 input clocks, where P is the prescale ratio. When a step lands on a counter that is already zero, the block records an underflow. In periodic mode the counter then reloads from the initial count. In one-shot mode the counter stays at zero and the timer disables itself. The underflow flag drives a level interrupt output, and the live count can be read at any time.

A three-state machine sequences the counter:

- **IDLE** is the stopped state.
- **LOAD** is a one-cycle state that copies the initial count into the counter.
- **RUN** is the state in which counting happens.

The transitions are:

- **start** (IDLE to LOAD) fires on a control write with the enable bit set.
- **arm** (LOAD to RUN) fires on the next cycle unless a control write clears the enable bit.
- **stop** (LOAD or RUN to IDLE) fires on a control write with the enable bit clear.
- **expire** (RUN to IDLE) fires on a one-shot underflow.
- **wrap** (RUN to RUN) fires on a periodic underflow.

Top module: `tdt_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and the timer is stopped.
- R2: The register map uses three offsets. Offset 0x00 is control: bit 30 is enable, bit 29 is the underflow flag, bit 27 selects periodic mode (1) or one-shot mode (0), and bits 7:0 hold the prescale P; all other control bits read 0. Offset 0x08 is the initial count, which keeps bits 23:0 of a write and reads bits 31:24 as 0. Reads of any other offset return 0.
- R3: Take a control write with bit 30 set, made while the timer is stopped, to land at clock edge k. The counter holds the initial count after edge k+1 and before its first decrement.
- R4: While running, the counter decrements once every P+1 clocks. Any control write restarts the prescale phase, so the first decrement after the write comes P+1 clocks after the cycle that follows it.
- R5: In periodic mode, a step taken while the count is zero reloads the initial count, so one period lasts (initial+1)·(P+1) clocks.
- R6: In one-shot mode, a step taken while the count is zero leaves the count at zero and clears the enable bit.
- R7: Every underflow sets the flag in bit 29, and `irq` equals that flag. Writing control with bit 29 = 1 clears the flag. Writing bit 29 = 0 leaves the flag unchanged.
- R8: Offset 0x10 returns the live count with bits 31:24 as 0. Writes to offset 0x10 change nothing.
- R9: A control write with bit 30 clear stops counting, and the count holds its value.
- R10: An initial count of 0xFFFFFF is kept in full, and counting starts from it without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, equal to the underflow flag |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the prescale ratio changes only through a control write, which restarts the phase. As a result, a step can never coincide with a reload request or with a write to the flag. The stimulus drives each strobe in its own cycle and changes the prescale only through control writes. It keeps the read strobe parked on the count offset between accesses, so the live count can be compared with the reference model on every clock.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } tdt_state_e;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_INIT  = 'h08;
    localparam int OFF_COUNT = 'h10;

    localparam int CTRL_EN_BIT   = 30;
    localparam int CTRL_FLAG_BIT = 29;
    localparam int CTRL_PER_BIT  = 27;

endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_clr,
    input  logic             run,
    input  logic [PRE_W-1:0] ratio,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == ratio);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_clr || !run || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && !phase_clr && at_end;

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] init,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);

    logic [CNT_W-1:0] count_q;
    logic             is_zero;

    assign is_zero   = (count_q == '0);
    assign underflow = tick && is_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= init;
        end else if (tick) begin
            if (is_zero) begin
                count_q <= periodic ? init : '0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/tdt_ctrl_fsm.sv
module tdt_ctrl_fsm
    import tdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_set,
    input  logic       en_clr,
    input  logic       underflow,
    input  logic       periodic,
    output logic       load,
    output logic       run,
    output logic       enabled,
    output tdt_state_e state
);

    tdt_state_e state_q;
    tdt_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_set) state_d = ST_LOAD;          // start
            end
            ST_LOAD: begin
                if (en_clr) state_d = ST_IDLE;          // stop
                else        state_d = ST_RUN;           // arm
            end
            ST_RUN: begin
                if (en_clr)                       state_d = ST_IDLE; // stop
                else if (underflow && !periodic)  state_d = ST_IDLE; // expire
                else                              state_d = ST_RUN;  // count or wrap
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        run     = 1'b0;
        enabled = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                load    = 1'b1;
                enabled = 1'b1;
            end
            ST_RUN: begin
                run     = 1'b1;
                enabled = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/tdt_timer.sv
module tdt_timer
    import tdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_INIT  = ADDR_W'(OFF_INIT);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);

    logic [CNT_W-1:0] init_q;
    logic [PRE_W-1:0] psc_q;
    logic             per_q;
    logic             flag_q;

    logic             wr_ctrl;
    logic             wr_init;
    logic             en_set;
    logic             en_clr;
    logic             tick;
    logic             load;
    logic             run;
    logic             enabled;
    logic             underflow;
    logic [CNT_W-1:0] count;
    tdt_state_e       state;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_init = wr_en && (addr == A_INIT);
    assign en_set  = wr_ctrl &&  wdata[CTRL_EN_BIT];
    assign en_clr  = wr_ctrl && !wdata[CTRL_EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            psc_q  <= '0;
            per_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_init) init_q <= wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                psc_q <= wdata[PRE_W-1:0];
                per_q <= wdata[CTRL_PER_BIT];
            end
            if (underflow)                           flag_q <= 1'b1;
            else if (wr_ctrl && wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    tdt_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_clr (wr_ctrl),
        .run       (run),
        .ratio     (psc_q),
        .tick      (tick)
    );

    tdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tick      (tick),
        .periodic  (per_q),
        .init      (init_q),
        .count     (count),
        .underflow (underflow)
    );

    tdt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .underflow (underflow),
        .periodic  (per_q),
        .load      (load),
        .run       (run),
        .enabled   (enabled),
        .state     (state)
    );

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[PRE_W-1:0]     = psc_q;
        ctrl_word[CTRL_PER_BIT]  = per_q;
        ctrl_word[CTRL_FLAG_BIT] = flag_q;
        ctrl_word[CTRL_EN_BIT]   = enabled;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_CTRL:  rdata = ctrl_word;
                A_INIT:  rdata = DATA_W'(init_q);
                A_COUNT: rdata = DATA_W'(count);
                default: rdata = '0;
            endcase
        end
    end

    assign irq = flag_q;

endmodule

// File: rtl/tdt_timer_checker.sv
module tdt_timer_checker
    import tdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              tick,
    input logic              load,
    input logic              run,
    input logic              periodic,
    input logic              underflow,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  init
);

    assert_count_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_COUNT)) |-> (rdata[DATA_W-1:CNT_W] == '0));

    assert_load_initial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(init)));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && periodic) |=> (count == $past(init)));

    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !periodic) |=> (count == '0 && !run));

    assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq);

endmodule

bind tdt_timer tdt_timer_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq       (irq),
    .tick      (tick),
    .load      (load),
    .run       (run),
    .periodic  (per_q),
    .underflow (underflow),
    .count     (count),
    .init      (init_q)
);

// File: tb/tdt_timer_bench.sv
`timescale 1ns/1ps
module tdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b1;
    logic [4:0]  addr = 5'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference model state
    int          m_state = 0;   // 0 stopped, 1 loading, 2 counting
    int          m_phase = 0;
    logic [31:0] m_cnt = '0;
    logic [31:0] m_init = '0;
    int          m_psc = 0;
    bit          m_per = 1'b0;
    bit          m_flag = 1'b0;

    always #10 clk = ~clk;

    tdt_timer u_tdt_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_phase = 0; m_cnt = '0; m_init = '0;
            m_psc = 0; m_per = 1'b0; m_flag = 1'b0;
        end else begin
            bit          wc, wi, stp, uf;
            int          nstate, nphase;
            logic [31:0] ncnt;
            wc  = wr_en && addr == 5'h00;
            wi  = wr_en && addr == 5'h08;
            stp = (m_state == 2) && !wc && (m_phase == m_psc);
            uf  = stp && (m_cnt == 0);
            nphase = (wc || m_state != 2 || m_phase == m_psc) ? 0 : m_phase + 1;
            ncnt = m_cnt;
            if (m_state == 1) ncnt = m_init;
            else if (stp) ncnt = (m_cnt == 0) ? (m_per ? m_init : 32'd0) : m_cnt - 1;
            nstate = m_state;
            case (m_state)
                0: if (wc && wdata[30]) nstate = 1;
                1: nstate = (wc && !wdata[30]) ? 0 : 2;
                default: if (wc && !wdata[30]) nstate = 0;
                         else if (uf && !m_per) nstate = 0;
            endcase
            if (uf) m_flag = 1'b1;
            else if (wc && wdata[29]) m_flag = 1'b0;
            if (wc) begin m_psc = int'(wdata[7:0]); m_per = wdata[27]; end
            if (wi) m_init = {8'h00, wdata[23:0]};
            m_state = nstate; m_phase = nphase; m_cnt = ncnt;
        end
    end

    // compare the live count and the interrupt with the model on every clock
    always @(negedge clk) begin
        if (rst_n && rd_en && !wr_en && addr == 5'h10 && !done) begin
            checks++;
            if (rdata !== m_cnt || irq !== m_flag) begin
                errors++;
                $display("FAIL %s: live count=%h irq=%b, expected count=%h irq=%b",
                         cur_tag, rdata, irq, m_cnt, m_flag);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        #1; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        #1; wr_en = 1'b0; rd_en = 1'b1; addr = 5'h10; wdata = '0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        #1; addr = a; rd_en = 1'b1;
        #1; checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: read %h got %h expected %h", tag, a, rdata, exp);
        end
        #1; addr = 5'h10;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] held;
        idle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h08, 32'h0, "R1");
        rd_chk(5'h10, 32'h0, "R1");
        irq_chk(1'b0, "R1");

        // R2 register map
        cur_tag = "R2";
        wr(5'h08, 32'hAB00_0005);
        rd_chk(5'h08, 32'h0000_0005, "R2");
        rd_chk(5'h04, 32'h0, "R2");
        rd_chk(5'h18, 32'h0, "R2");

        // R3 enable rise loads the initial count; periodic P=2
        cur_tag = "R3";
        wr(5'h00, 32'h4800_0002);
        rd_chk(5'h00, 32'h4800_0002, "R2");
        @(negedge clk);
        rd_chk(5'h10, 32'h0000_0005, "R3");

        // R5 periodic wrap over several periods
        cur_tag = "R5";
        idle(60);
        irq_chk(1'b1, "R7");

        // R7 clear the flag by writing 1 to bit 29
        cur_tag = "R7";
        wr(5'h00, 32'h6800_0002);
        irq_chk(1'b0, "R7");
        rd_chk(5'h00, 32'h4800_0002, "R7");
        idle(30);
        irq_chk(1'b1, "R7");
        wr(5'h00, 32'h4800_0002);
        irq_chk(1'b1, "R7");

        // R8 write to the count offset is ignored
        cur_tag = "R8";
        wr(5'h10, 32'hFFFF_0123);
        rd_chk(5'h10, m_cnt, "R8");
        idle(5);

        // R9 disable holds the count
        cur_tag = "R9";
        wr(5'h00, 32'h0800_0002);
        held = m_cnt;
        idle(10);
        rd_chk(5'h10, held, "R9");
        rd_chk(5'h00, 32'h2800_0002, "R9");

        // R6 one-shot from 3 with P=0, clearing the flag on the way
        cur_tag = "R6";
        wr(5'h08, 32'h0000_0003);
        wr(5'h00, 32'h6000_0000);
        irq_chk(1'b0, "R7");
        idle(10);
        rd_chk(5'h00, 32'h2000_0000, "R6");
        rd_chk(5'h10, 32'h0, "R6");
        irq_chk(1'b1, "R7");

        // R4 prescale P=4, periodic, initial 2
        cur_tag = "R4";
        wr(5'h08, 32'h0000_0002);
        wr(5'h00, 32'h6800_0004);
        @(negedge clk);
        rd_chk(5'h10, 32'h2, "R4");
        idle(4);
        rd_chk(5'h10, 32'h2, "R4");
        @(negedge clk);
        rd_chk(5'h10, 32'h1, "R4");
        idle(7);
        wr(5'h00, 32'h4800_0004);   // phase restart mid-run
        idle(40);

        // R10 full-width initial count
        cur_tag = "R10";
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h00FF_FFFF);
        rd_chk(5'h08, 32'h00FF_FFFF, "R10");
        wr(5'h00, 32'h4800_0000);
        @(negedge clk);
        rd_chk(5'h10, 32'h00FF_FFFF, "R10");
        @(negedge clk);
        rd_chk(5'h10, 32'h00FF_FFFE, "R10");
        idle(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule